// File: doc/BRIEF.md
# Pin-Slot Mailbox Data Node

This block turns one pin slot into a small mailbox between processor cores. A core picks one of three data-node modes (8, 16 or 32 bits) through a configuration write, with the pin's DAC enable off. After that, any core can post a value through the data-write port. The value passes through a short, fixed issue pipeline. It is then masked to the selected width, zero-extended, and stored in the result register. At the same moment the IN flag is raised. Every core can read the result register.

Cores that wait for new data watch a one-cycle rise event. Because the latency is fixed, every waiter wakes on the same, known cycle after the write. A reader clears IN by pulsing the acknowledge input. Reading alone never clears it. If any other mode code is configured, or the DAC enable is set, the mailbox is disabled and its state is wiped.

Top module: `pin_mailbox_node`

## Requirements
- R1: After reset, `rd_data_o` is 0, `flag_o` and `flag_rise_o` are 0, and the configuration is inactive, so data writes have no effect until a data-node mode is configured.
- R2: With the DAC bit off, mode code 5'b00001 stores bits [7:0] of the written value, 5'b00010 stores bits [15:0] and 5'b00011 stores all 32 bits. The upper bits of `rd_data_o` are zero.
- R3: If the configuration has the DAC bit set, or holds any mode code other than 1, 2 or 3, a data write that reaches commit leaves `rd_data_o` and `flag_o` unchanged.
- R4: A write sampled at clock edge n (with the default of 3 issue stages) updates `rd_data_o` and sets `flag_o` at edge n+3. This is the fourth cycle counting the issue cycle. Writes on back-to-back cycles commit in order, and the last one remains in `rd_data_o`.
- R5: Once `flag_o` is set, it stays high, and `rd_data_o` holds its value, until a commit, an acknowledge or a configuration write occurs.
- R6: `ack_i` sampled high with no commit on the same edge clears `flag_o` at that edge. `rd_data_o` is kept.
- R7: When a valid commit and `ack_i` fall on the same edge, the commit wins: `flag_o` stays or becomes 1, and the new value is stored.
- R8: A configuration write whose new value is inactive (DAC bit set, or a mode code other than 1..3) clears `rd_data_o` and `flag_o` at that edge. This takes priority over a commit on the same edge.
- R9: `flag_rise_o` is high for exactly the first cycle in which `flag_o` is high after being low. A commit while `flag_o` is already high produces no pulse.
- R10: A commit uses the configuration held before its edge, regardless of the configuration at issue time. Switching between the three data-node modes keeps `rd_data_o` and `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 5 | Mode code to configure |
| cfg_dac_i | input | 1 | DAC enable bit to configure |
| wr_valid_i | input | 1 | Data write issue strobe |
| wr_data_i | input | 32 | Data to post |
| ack_i | input | 1 | Acknowledge, clears the IN flag |
| rd_data_o | output | 32 | Result register contents |
| flag_o | output | 1 | IN flag, new data available |
| flag_rise_o | output | 1 | One-cycle event on the rising edge of IN |

## Verification
The hardest situations to reach are those where a write is still in flight in the issue pipeline when the configuration changes or an acknowledge arrives. Examples are an acknowledge landing exactly on the commit edge, and a mode switch between issue and commit. The directed part times these coincidences by counting pipeline edges. The seeded random part writes on about a third of cycles, acknowledges on a quarter, and reconfigures occasionally, so these collisions also happen in many combinations. Every cycle is compared against a cycle-level reference model.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned MW = 5;

  typedef enum logic [1:0] {W_NONE, W_BYTE, W_HALF, W_WORD} width_e;

  function automatic width_e decode_width(logic [MW-1:0] mode, logic dac);
    if (dac) return W_NONE;
    case (mode)
      5'b00001: return W_BYTE;
      5'b00010: return W_HALF;
      5'b00011: return W_WORD;
      default:  return W_NONE;
    endcase
  endfunction

  function automatic logic [DW-1:0] width_mask(width_e w);
    case (w)
      W_BYTE:  return DW'(32'h0000_00FF);
      W_HALF:  return DW'(32'h0000_FFFF);
      W_WORD:  return '1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pmb_cfg.sv
`timescale 1ns/1ps
module pmb_cfg
  import pmb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [MW-1:0] mode_i,
  input  logic          dac_i,
  output width_e        width_o,
  output logic          clr_o
);
  logic [MW-1:0] mode_q;
  logic          dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dac_q  <= 1'b0;
    end else if (we_i) begin
      mode_q <= mode_i;
      dac_q  <= dac_i;
    end
  end

  // width in force for a commit on the next edge
  assign width_o = decode_width(mode_q, dac_q);
  // leaving data-node behaviour wipes the cell
  assign clr_o   = we_i && (decode_width(mode_i, dac_i) == W_NONE);
endmodule

// File: rtl/pmb_issue_pipe.sv
`timescale 1ns/1ps
module pmb_issue_pipe #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned DW     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  output logic          v_o,
  output logic [DW-1:0] d_o
);
  if (STAGES == 0) begin : g_bypass
    assign v_o = v_i;
    assign d_o = d_i;
  end else begin : g_pipe
    logic [STAGES-1:0] v_q;
    logic [DW-1:0]     d_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic          v_in;
      logic [DW-1:0] d_in;
      if (i == 0) begin : g_head
        assign v_in = v_i;
        assign d_in = d_i;
      end else begin : g_body
        assign v_in = v_q[i-1];
        assign d_in = d_q[i-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[i] <= 1'b0;
          d_q[i] <= '0;
        end else begin
          v_q[i] <= v_in;
          d_q[i] <= d_in;
        end
      end
    end

    assign v_o = v_q[STAGES-1];
    assign d_o = d_q[STAGES-1];
  end
endmodule

// File: rtl/pmb_flag_ctrl.sv
`timescale 1ns/1ps
module pmb_flag_ctrl
  import pmb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          commit_v_i,
  input  logic [DW-1:0] commit_d_i,
  input  width_e        width_i,
  input  logic          ack_i,
  output logic [DW-1:0] z_o,
  output logic          flag_o,
  output logic          rise_o
);
  logic [DW-1:0] z_q;
  logic          flag_q, flag_dly_q;
  logic          take;

  assign take = commit_v_i && (width_i != W_NONE);

  // priority: clear, then commit, then acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q    <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      z_q    <= '0;
      flag_q <= 1'b0;
    end else if (take) begin
      z_q    <= commit_d_i & width_mask(width_i);
      flag_q <= 1'b1;
    end else if (ack_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_dly_q <= 1'b0;
    else         flag_dly_q <= flag_q;
  end

  assign z_o    = z_q;
  assign flag_o = flag_q;
  assign rise_o = flag_q & ~flag_dly_q;
endmodule

// File: rtl/pin_mailbox_node.sv
`timescale 1ns/1ps
module pin_mailbox_node
  import pmb_pkg::*;
#(
  parameter int unsigned PIPE_STAGES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [4:0]    cfg_mode_i,
  input  logic          cfg_dac_i,
  input  logic          wr_valid_i,
  input  logic [31:0]   wr_data_i,
  input  logic          ack_i,
  output logic [31:0]   rd_data_o,
  output logic          flag_o,
  output logic          flag_rise_o
);
  width_e        cfg_width;
  logic          cfg_clr;
  logic          commit_v;
  logic [DW-1:0] commit_d;

  pmb_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .mode_i  (cfg_mode_i),
    .dac_i   (cfg_dac_i),
    .width_o (cfg_width),
    .clr_o   (cfg_clr)
  );

  pmb_issue_pipe #(.STAGES(PIPE_STAGES), .DW(DW)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (wr_valid_i),
    .d_i    (wr_data_i),
    .v_o    (commit_v),
    .d_o    (commit_d)
  );

  pmb_flag_ctrl u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cfg_clr),
    .commit_v_i (commit_v),
    .commit_d_i (commit_d),
    .width_i    (cfg_width),
    .ack_i      (ack_i),
    .z_o        (rd_data_o),
    .flag_o     (flag_o),
    .rise_o     (flag_rise_o)
  );
endmodule

// File: rtl/pin_mailbox_node_chk.sv
`timescale 1ns/1ps
module pin_mailbox_node_chk
  import pmb_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [4:0]  cfg_mode_i,
  input logic        cfg_dac_i,
  input logic        ack_i,
  input logic [31:0] rd_data_o,
  input logic        flag_o,
  input logic        flag_rise_o,
  input logic        commit_v_i,
  input width_e      commit_w_i
);
  logic leave_node;
  assign leave_node = cfg_we_i && (cfg_dac_i || !(cfg_mode_i inside {5'd1, 5'd2, 5'd3}));

  assert_rise_has_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_rise_o |-> flag_o);
  assert_rise_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_rise_o |=> !flag_rise_o);
  assert_clear_on_leave_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leave_node |=> (!flag_o && rd_data_o == 32'd0));
  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_v_i && commit_w_i != W_NONE && !cfg_we_i) |=> flag_o);
  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !commit_v_i && !cfg_we_i) |=> (!flag_o && $stable(rd_data_o)));
  assert_byte_zero_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_v_i && commit_w_i == W_BYTE && !cfg_we_i) |=> rd_data_o[31:8] == 24'd0);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_v_i && !ack_i && !cfg_we_i) |=> ($stable(flag_o) && $stable(rd_data_o)));
  assert_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_v_i && commit_w_i == W_NONE && !ack_i && !cfg_we_i)
      |=> ($stable(flag_o) && $stable(rd_data_o)));
endmodule

bind pin_mailbox_node pin_mailbox_node_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_mode_i  (cfg_mode_i),
  .cfg_dac_i   (cfg_dac_i),
  .ack_i       (ack_i),
  .rd_data_o   (rd_data_o),
  .flag_o      (flag_o),
  .flag_rise_o (flag_rise_o),
  .commit_v_i  (commit_v),
  .commit_w_i  (cfg_width)
);

// File: tb/pin_mailbox_node_tb_top.sv
`timescale 1ns/1ps
module pin_mailbox_node_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_mode_i = '0;
  logic        cfg_dac_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        ack_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        flag_o;
  logic        flag_rise_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  pin_mailbox_node dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_mode_i, .cfg_dac_i,
    .wr_valid_i, .wr_data_i, .ack_i, .rd_data_o, .flag_o, .flag_rise_o
  );

  // reference model, built from the requirements
  logic [4:0]  m_mode = '0;
  logic        m_dac  = 1'b0;
  logic [2:0]  m_pv   = '0;
  logic [31:0] m_pd [3];
  logic [31:0] m_z    = '0;
  logic        m_flag = 1'b0;
  logic        m_prev = 1'b0;

  function automatic logic [31:0] ref_mask(logic [4:0] mode, logic dac);
    if (dac) return 32'h0;
    case (mode)
      5'd1: return 32'h0000_00FF;
      5'd2: return 32'h0000_FFFF;
      5'd3: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic clr;
    logic [31:0] mk;
    clr = cfg_we_i && (ref_mask(cfg_mode_i, cfg_dac_i) == 32'h0);
    mk  = ref_mask(m_mode, m_dac);
    m_prev = m_flag;
    if (clr) begin
      m_z = '0; m_flag = 1'b0;
    end else if (m_pv[2] && mk != 32'h0) begin
      m_z = m_pd[2] & mk; m_flag = 1'b1;
    end else if (ack_i) begin
      m_flag = 1'b0;
    end
    m_pv[2] = m_pv[1]; m_pd[2] = m_pd[1];
    m_pv[1] = m_pv[0]; m_pd[1] = m_pd[0];
    m_pv[0] = wr_valid_i; m_pd[0] = wr_data_i;
    if (cfg_we_i) begin
      m_mode = cfg_mode_i; m_dac = cfg_dac_i;
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2 R4 R10", "rd_data", rd_data_o, m_z);
    chk("R5 R6 R7 R8", "flag", 32'(flag_o), 32'(m_flag));
    chk("R9", "rise", 32'(flag_rise_o), 32'(m_flag & ~m_prev));
  endtask

  // one cycle: compare at negedge, drive, advance model at posedge
  task automatic cyc(logic we, logic [4:0] mode, logic dac, logic wv, logic [31:0] wd, logic ak);
    cmp_model();
    cfg_we_i = we; cfg_mode_i = mode; cfg_dac_i = dac;
    wr_valid_i = wv; wr_data_i = wd; ack_i = ak;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 5'd0, 0, 0, 32'h0, 0);
  endtask

  task automatic expect_now(string tag, logic [31:0] rd, logic fl, logic ri);
    chk(tag, "rd_data", rd_data_o, rd);
    chk(tag, "flag", 32'(flag_o), 32'(fl));
    chk(tag, "rise", 32'(flag_rise_o), 32'(ri));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    m_pd[0] = '0; m_pd[1] = '0; m_pd[2] = '0;
    seed = 32'd20240613;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    expect_now("R1", 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_now("R1", 32'h0, 1'b0, 1'b0);

    // write before any mode configured: ignored
    cyc(0, 5'd0, 0, 1, 32'hCAFE_F00D, 0);
    idle(5);
    expect_now("R1", 32'h0, 1'b0, 1'b0);

    // byte mode, latency and zero extension
    cyc(1, 5'd1, 0, 0, 32'h0, 0);
    cyc(0, 5'd0, 0, 1, 32'hDEAD_BEEF, 0);
    idle(2);
    expect_now("R4", 32'h0, 1'b0, 1'b0);
    idle(1);
    expect_now("R2 R4 R9", 32'h0000_00EF, 1'b1, 1'b1);
    idle(1);
    expect_now("R9 R5", 32'h0000_00EF, 1'b1, 1'b0);
    idle(4);
    expect_now("R5", 32'h0000_00EF, 1'b1, 1'b0);
    cyc(0, 5'd0, 0, 0, 32'h0, 1);
    expect_now("R6", 32'h0000_00EF, 1'b0, 1'b0);

    // halfword mode
    cyc(1, 5'd2, 0, 0, 32'h0, 0);
    cyc(0, 5'd0, 0, 1, 32'h1234_5678, 0);
    idle(3);
    expect_now("R2", 32'h0000_5678, 1'b1, 1'b1);

    // word mode switch keeps state, then overwrite while set: no rise
    cyc(1, 5'd3, 0, 0, 32'h0, 0);
    expect_now("R10", 32'h0000_5678, 1'b1, 1'b0);
    cyc(0, 5'd0, 0, 1, 32'h8765_4321, 0);
    idle(3);
    expect_now("R2 R9", 32'h8765_4321, 1'b1, 1'b0);

    // ack on the commit edge: write wins
    cyc(0, 5'd0, 0, 0, 32'h0, 1);
    expect_now("R6", 32'h8765_4321, 1'b0, 1'b0);
    cyc(0, 5'd0, 0, 1, 32'hA5A5_0001, 0);
    idle(2);
    cyc(0, 5'd0, 0, 0, 32'h0, 1);
    expect_now("R7", 32'hA5A5_0001, 1'b1, 1'b1);

    // back-to-back writes, last one remains
    cyc(0, 5'd0, 0, 1, 32'h0000_0011, 0);
    cyc(0, 5'd0, 0, 1, 32'h0000_0022, 0);
    idle(3);
    expect_now("R4", 32'h0000_0022, 1'b1, 1'b0);

    // issue under byte, commit under word
    cyc(1, 5'd1, 0, 1, 32'h7777_1234, 0);
    cyc(1, 5'd3, 0, 0, 32'h0, 0);
    idle(2);
    expect_now("R10", 32'h7777_1234, 1'b1, 1'b0);

    // DAC enable clears and disables, even against a commit
    cyc(0, 5'd0, 0, 1, 32'h5555_5555, 0);
    idle(2);
    cyc(1, 5'd3, 1, 0, 32'h0, 0);
    expect_now("R8", 32'h0, 1'b0, 1'b0);
    cyc(0, 5'd0, 0, 1, 32'h9999_9999, 0);
    idle(4);
    expect_now("R3", 32'h0, 1'b0, 1'b0);

    // other mode code: data write ignored after refill
    cyc(1, 5'd3, 0, 1, 32'h0BAD_0BAD, 0);
    idle(3);
    expect_now("R2", 32'h0BAD_0BAD, 1'b1, 1'b1);
    cyc(1, 5'd4, 0, 0, 32'h0, 0);
    expect_now("R8", 32'h0, 1'b0, 1'b0);
    cyc(0, 5'd0, 0, 1, 32'h1111_2222, 0);
    idle(4);
    expect_now("R3", 32'h0, 1'b0, 1'b0);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic we, dac, wv, ak;
      logic [4:0] md;
      we  = ($urandom_range(15) == 0);
      md  = 5'($urandom_range(7));
      dac = ($urandom_range(3) == 0);
      wv  = ($urandom_range(2) == 0);
      ak  = ($urandom_range(3) == 0);
      cyc(we, md, dac, wv, $urandom, ak);
    end
    cmp_model();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule